// File: doc/BRIEF.md
# Pop-Suppressing Output Power Sequencer

This block steps the output stage of an audio converter through reset, setup, power-up and power-down. It works for outputs whose DC-blocking capacitors are outside the chip. At power-up the outputs are held at ground for a set number of sample-rate (left/right) clock periods. The quiescent level then rises in a straight line to full scale, and only after that is audio enabled. At power-down the output buffers are disconnected and a slow current sink drains the capacitors. Each of these phases is timed in left/right clock strobes.

A mode pin is captured once, on the first clock after reset is released. In control-port mode the block waits for a power-down bit, supplied by a register file outside this block, to go to 0. In stand-alone mode it starts by itself and ignores that bit. If the transient-control enable is 0 at the moment of start, power-up is a short fixed count of system clocks and there is no clamp or ramp.

Top module: `dac_pwr_seq`

## Requirements
- R1: While `rst_n` is low, the outputs are: `clamp_o`=1, `ramp_level_o`=0, and every other output 0.
- R2: `mode_sel_i` is captured on the first clock edge after `rst_n` rises (1 = control port, 0 = stand-alone). Later changes on the pin have no effect until the next reset.
- R3: In control-port mode, `port_ready_o` is 1 from that first edge on. While `pdn_bit_i`=1 the block stays clamped, with no buffer connection and no audio.
- R4: If `tc_en_i`=0 at start, `buf_conn_o` is 1 for exactly FAST_CLKS system clocks, with the clamp released. After that `audio_en_o` goes to 1.
- R5: If `tc_en_i`=1 at start, `clamp_o` stays 1 until the CLAMP_LRCK-th `lr_stb_i` pulse after start, and drops on that pulse.
- R6: During the ramp `ramp_busy_o`=1 and `buf_conn_o`=1. After the k-th ramp strobe, `ramp_level_o` = floor(k·(2^LEVEL_W−1)/RAMP_LRCK). The level changes only on strobes.
- R7: On the RAMP_LRCK-th ramp strobe, `audio_en_o` goes to 1 and `ramp_busy_o` to 0. `ramp_level_o` is all ones whenever audio is enabled.
- R8: In control-port mode, `pdn_bit_i`=1 while audio is on switches off audio on the next edge. On that edge `sink_en_o` goes to 1 and the level goes to 0. After SINK_LRCK strobes `sink_en_o` falls and `dis_done_o` rises. The block then waits until `pdn_bit_i`=0 starts it again.
- R9: At most one of `audio_en_o`, `buf_conn_o` and `sink_en_o` is 1 in any cycle.
- R10: In control-port mode, `pdn_bit_i`=1 during the fast delay, the clamp or the ramp aborts power-up on the next edge. On that edge `sink_en_o` goes to 1, and `clamp_o`, `ramp_busy_o` and the level go to 0. This abort wins over the end of a phase in the same cycle.
- R11: In stand-alone mode, `port_ready_o` stays 0 and power-up starts one clock after the mode is captured. `pdn_bit_i` has no effect.
- R12: Pulling `rst_n` low in any phase returns all outputs to the R1 state at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_sel_i | input | 1 | Mode pin: 1 control port, 0 stand-alone |
| pdn_bit_i | input | 1 | Power-down request from the register file (default 1) |
| tc_en_i | input | 1 | Transient-control enable: selects clamp and ramp over fast start |
| lr_stb_i | input | 1 | One-cycle strobe per left/right clock period |
| clamp_o | output | 1 | Clamp outputs to ground |
| ramp_level_o | output | LEVEL_W | Quiescent-level code |
| ramp_busy_o | output | 1 | Ramp in progress |
| audio_en_o | output | 1 | Audio output enabled |
| buf_conn_o | output | 1 | Buffers connected, audio muted |
| sink_en_o | output | 1 | Discharge current sink enabled |
| port_ready_o | output | 1 | Control port accessible |
| dis_done_o | output | 1 | Discharge finished, block powered down |

## Verification
The assertions assume that `lr_stb_i` is a single-cycle pulse synchronous to `clk`, and that `rst_n` is released between clock edges. They also assume `pdn_bit_i` only matters once the mode has been captured. The stimulus drives every input on the falling edge and spaces strobes by a random gap of zero to two idle cycles. It moves `pdn_bit_i` only at phase points chosen by the bench, or at random strobe counts inside the clamp and ramp. It changes the mode pin after capture to show that the change has no effect.

// File: rtl/dac_pwr_seq_pkg.sv
package dac_pwr_seq_pkg;

    typedef enum logic [2:0] {
        ST_RST   = 3'd0,
        ST_IDLE  = 3'd1,
        ST_FAST  = 3'd2,
        ST_CLAMP = 3'd3,
        ST_RAMP  = 3'd4,
        ST_RUN   = 3'd5,
        ST_SINK  = 3'd6,
        ST_OFF   = 3'd7
    } seq_state_e;

    typedef struct packed {
        seq_state_e state;
        logic       mode_cp;
        logic       clamp;
        logic       busy;
        logic       audio;
        logic       bufc;
        logic       sink;
        logic       ready;
        logic       done;
    } seq_regs_t;

    localparam seq_regs_t SEQ_RESET = '{
        state:   ST_RST,
        mode_cp: 1'b0,
        clamp:   1'b1,
        busy:    1'b0,
        audio:   1'b0,
        bufc:    1'b0,
        sink:    1'b0,
        ready:   1'b0,
        done:    1'b0
    };

    function automatic seq_regs_t seq_decode(seq_state_e s, logic cp);
        seq_regs_t r;
        r.state   = s;
        r.mode_cp = cp;
        r.clamp   = (s == ST_RST) || (s == ST_IDLE) || (s == ST_CLAMP);
        r.busy    = (s == ST_RAMP);
        r.audio   = (s == ST_RUN);
        r.bufc    = (s == ST_FAST) || (s == ST_RAMP);
        r.sink    = (s == ST_SINK);
        r.ready   = cp && (s != ST_RST);
        r.done    = (s == ST_OFF);
        return r;
    endfunction

endpackage

// File: rtl/seq_phase_cnt.sv
module seq_phase_cnt #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             inc_i,
    input  logic [CNT_W-1:0] limit_i,
    output logic             hit_o
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i) begin
            cnt_d = '0;
        end else if (inc_i) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    assign hit_o = inc_i && (cnt_q == (limit_i - 1'b1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/seq_ramp_gen.sv
module seq_ramp_gen #(
    parameter int unsigned LEVEL_W = 16,
    parameter int unsigned STEPS   = 10000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr_i,
    input  logic               adv_i,
    input  logic               fill_i,
    output logic [LEVEL_W-1:0] level_o
);

    localparam longint unsigned FULL_L = (64'd1 << LEVEL_W) - 64'd1;
    localparam longint unsigned STEP_L = FULL_L / STEPS;
    localparam longint unsigned REM_L  = FULL_L % STEPS;
    localparam int unsigned     RW     = $clog2(STEPS + 1);

    localparam logic [LEVEL_W-1:0] STEP    = LEVEL_W'(STEP_L);
    localparam logic [RW:0]        REM_INC = (RW + 1)'(REM_L);
    localparam logic [RW:0]        DIVISOR = (RW + 1)'(STEPS);

    logic [LEVEL_W-1:0] level_d, level_q;
    logic [RW-1:0]      rem_d, rem_q;
    logic [RW:0]        rem_sum;
    logic               carry;

    always_comb begin
        rem_sum = {1'b0, rem_q} + REM_INC;
        carry   = (rem_sum >= DIVISOR);
        level_d = level_q;
        rem_d   = rem_q;
        if (fill_i) begin
            level_d = '1;
            rem_d   = '0;
        end else if (clr_i) begin
            level_d = '0;
            rem_d   = '0;
        end else if (adv_i) begin
            level_d = level_q + STEP + LEVEL_W'(carry);
            rem_d   = carry ? RW'(rem_sum - DIVISOR) : RW'(rem_sum);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            level_q <= '0;
            rem_q   <= '0;
        end else begin
            level_q <= level_d;
            rem_q   <= rem_d;
        end
    end

    assign level_o = level_q;

endmodule

// File: rtl/dac_pwr_seq.sv
module dac_pwr_seq
    import dac_pwr_seq_pkg::*;
#(
    parameter int unsigned LEVEL_W    = 16,
    parameter int unsigned CLAMP_LRCK = 1000,
    parameter int unsigned RAMP_LRCK  = 10000,
    parameter int unsigned SINK_LRCK  = 4000,
    parameter int unsigned FAST_CLKS  = 614
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               mode_sel_i,
    input  logic               pdn_bit_i,
    input  logic               tc_en_i,
    input  logic               lr_stb_i,
    output logic               clamp_o,
    output logic [LEVEL_W-1:0] ramp_level_o,
    output logic               ramp_busy_o,
    output logic               audio_en_o,
    output logic               buf_conn_o,
    output logic               sink_en_o,
    output logic               port_ready_o,
    output logic               dis_done_o
);

    localparam int unsigned MAX_AB  = (CLAMP_LRCK > RAMP_LRCK) ? CLAMP_LRCK : RAMP_LRCK;
    localparam int unsigned MAX_CD  = (SINK_LRCK > FAST_CLKS) ? SINK_LRCK : FAST_CLKS;
    localparam int unsigned CNT_MAX = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
    localparam int unsigned CNT_W   = $clog2(CNT_MAX + 1);

    localparam logic [CNT_W-1:0] LIM_CLAMP = CNT_W'(CLAMP_LRCK);
    localparam logic [CNT_W-1:0] LIM_RAMP  = CNT_W'(RAMP_LRCK);
    localparam logic [CNT_W-1:0] LIM_SINK  = CNT_W'(SINK_LRCK);
    localparam logic [CNT_W-1:0] LIM_FAST  = CNT_W'(FAST_CLKS);

    seq_regs_t        cur_q, nxt_d;
    logic             cnt_clr, cnt_inc, cnt_hit;
    logic [CNT_W-1:0] cnt_limit;
    logic             abort_req, start_req;
    seq_state_e       start_state;
    logic             ramp_clr, ramp_adv, ramp_fill;

    // Phase counter control follows the present state
    always_comb begin
        cnt_inc   = 1'b0;
        cnt_limit = LIM_CLAMP;
        unique case (cur_q.state)
            ST_FAST: begin
                cnt_inc   = 1'b1;
                cnt_limit = LIM_FAST;
            end
            ST_CLAMP: begin
                cnt_inc   = lr_stb_i;
                cnt_limit = LIM_CLAMP;
            end
            ST_RAMP: begin
                cnt_inc   = lr_stb_i;
                cnt_limit = LIM_RAMP;
            end
            ST_SINK: begin
                cnt_inc   = lr_stb_i;
                cnt_limit = LIM_SINK;
            end
            default: begin
                cnt_inc   = 1'b0;
                cnt_limit = LIM_CLAMP;
            end
        endcase
    end

    seq_phase_cnt #(
        .CNT_W (CNT_W)
    ) u_phase_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (cnt_clr),
        .inc_i   (cnt_inc),
        .limit_i (cnt_limit),
        .hit_o   (cnt_hit)
    );

    // Next-state and registered-output computation
    always_comb begin
        seq_state_e ns;
        logic       cp;
        ns          = cur_q.state;
        cp          = cur_q.mode_cp;
        abort_req   = cur_q.mode_cp && pdn_bit_i;
        start_req   = !cur_q.mode_cp || !pdn_bit_i;
        start_state = tc_en_i ? ST_CLAMP : ST_FAST;

        unique case (cur_q.state)
            ST_RST: begin
                ns = ST_IDLE;
                cp = mode_sel_i;
            end
            ST_IDLE, ST_OFF: begin
                if (start_req) begin
                    ns = start_state;
                end
            end
            ST_FAST: begin
                if (abort_req) begin
                    ns = ST_SINK;
                end else if (cnt_hit) begin
                    ns = ST_RUN;
                end
            end
            ST_CLAMP: begin
                if (abort_req) begin
                    ns = ST_SINK;
                end else if (cnt_hit) begin
                    ns = ST_RAMP;
                end
            end
            ST_RAMP: begin
                if (abort_req) begin
                    ns = ST_SINK;
                end else if (cnt_hit) begin
                    ns = ST_RUN;
                end
            end
            ST_RUN: begin
                if (abort_req) begin
                    ns = ST_SINK;
                end
            end
            ST_SINK: begin
                if (cnt_hit) begin
                    ns = ST_OFF;
                end
            end
            default: ns = ST_RST;
        endcase

        nxt_d     = seq_decode(ns, cp);
        cnt_clr   = (ns != cur_q.state);
        ramp_fill = (ns == ST_RUN);
        ramp_clr  = (ns != ST_RAMP) && (ns != ST_RUN);
        ramp_adv  = (cur_q.state == ST_RAMP) && lr_stb_i;
    end

    seq_ramp_gen #(
        .LEVEL_W (LEVEL_W),
        .STEPS   (RAMP_LRCK)
    ) u_ramp (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (ramp_clr),
        .adv_i   (ramp_adv),
        .fill_i  (ramp_fill),
        .level_o (ramp_level_o)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= SEQ_RESET;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign clamp_o      = cur_q.clamp;
    assign ramp_busy_o  = cur_q.busy;
    assign audio_en_o   = cur_q.audio;
    assign buf_conn_o   = cur_q.bufc;
    assign sink_en_o    = cur_q.sink;
    assign port_ready_o = cur_q.ready;
    assign dis_done_o   = cur_q.done;

endmodule

// File: rtl/dac_pwr_seq_chk.sv
module dac_pwr_seq_chk #(
    parameter int unsigned LEVEL_W = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               pdn_bit_i,
    input logic               lr_stb_i,
    input logic               clamp_o,
    input logic [LEVEL_W-1:0] ramp_level_o,
    input logic               ramp_busy_o,
    input logic               audio_en_o,
    input logic               buf_conn_o,
    input logic               sink_en_o,
    input logic               port_ready_o,
    input logic               dis_done_o
);

    // R1: first edge after release still shows the reset outputs
    a_r1_reset_outputs: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (clamp_o && !audio_en_o && !port_ready_o && ramp_level_o == '0));

    // R2: captured mode does not move afterwards
    a_r2_mode_held: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rst_n, 2)) |-> $stable(port_ready_o));

    // R3: a held power-down request keeps audio off
    a_r3_hold_off: assert property (@(posedge clk) disable iff (!rst_n)
        (port_ready_o && pdn_bit_i && !audio_en_o) |=> !audio_en_o);

    // R6: level never falls during the ramp
    a_r6_level_rises: assert property (@(posedge clk) disable iff (!rst_n)
        (ramp_busy_o && $past(ramp_busy_o)) |-> (ramp_level_o >= $past(ramp_level_o)));

    // R6: no strobe, no level change (unless aborted)
    a_r6_level_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (ramp_busy_o && !lr_stb_i) |=> ((ramp_level_o == $past(ramp_level_o)) || sink_en_o));

    // R7: audio only at full scale
    a_r7_audio_full: assert property (@(posedge clk) disable iff (!rst_n)
        audio_en_o |-> (ramp_level_o == '1));

    // R8: done flag excludes active paths
    a_r8_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        dis_done_o |-> (!sink_en_o && !audio_en_o && !buf_conn_o));

    // R9: mutually exclusive output paths
    a_r9_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({audio_en_o, buf_conn_o, sink_en_o}));

    // R10: power-down during ramp aborts on the next edge
    a_r10_ramp_abort: assert property (@(posedge clk) disable iff (!rst_n)
        (ramp_busy_o && port_ready_o && pdn_bit_i) |=> (sink_en_o && !ramp_busy_o));

endmodule

bind dac_pwr_seq dac_pwr_seq_chk #(.LEVEL_W(LEVEL_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .pdn_bit_i    (pdn_bit_i),
    .lr_stb_i     (lr_stb_i),
    .clamp_o      (clamp_o),
    .ramp_level_o (ramp_level_o),
    .ramp_busy_o  (ramp_busy_o),
    .audio_en_o   (audio_en_o),
    .buf_conn_o   (buf_conn_o),
    .sink_en_o    (sink_en_o),
    .port_ready_o (port_ready_o),
    .dis_done_o   (dis_done_o)
);

// File: tb/dac_pwr_seq_tb.sv
module dac_pwr_seq_tb;

    localparam int unsigned CLK_PERIOD = 10;
    localparam int unsigned LW    = 16;
    localparam int unsigned CLAMP = 12;
    localparam int unsigned RAMP  = 40;
    localparam int unsigned SINK  = 10;
    localparam int unsigned FAST  = 25;
    localparam longint FULL = (64'sd1 <<< LW) - 64'sd1;

    logic clk = 1'b0;
    logic rst_n, mode_sel, pdn_bit, tc_en, lr_stb;
    logic clamp, busy, audio, bufc, sink, ready, done;
    logic [LW-1:0] level;
    logic mon_on = 1'b0;

    int total = 0;
    int bad   = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    dac_pwr_seq #(
        .LEVEL_W    (LW),
        .CLAMP_LRCK (CLAMP),
        .RAMP_LRCK  (RAMP),
        .SINK_LRCK  (SINK),
        .FAST_CLKS  (FAST)
    ) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .mode_sel_i   (mode_sel),
        .pdn_bit_i    (pdn_bit),
        .tc_en_i      (tc_en),
        .lr_stb_i     (lr_stb),
        .clamp_o      (clamp),
        .ramp_level_o (level),
        .ramp_busy_o  (busy),
        .audio_en_o   (audio),
        .buf_conn_o   (bufc),
        .sink_en_o    (sink),
        .port_ready_o (ready),
        .dis_done_o   (done)
    );

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic longint ramp_exp(input int k);
        return (longint'(k) * FULL) / longint'(RAMP);
    endfunction

    task automatic tick(input logic s);
        lr_stb = s;
        @(negedge clk);
        lr_stb = 1'b0;
    endtask

    task automatic strobe();
        int g = $urandom_range(0, 2);
        repeat (g) tick(1'b0);
        tick(1'b1);
    endtask

    // R9 exclusivity monitor
    always @(negedge clk) begin
        if (mon_on) begin
            chk("R9", "paths<=1", longint'($countones({audio, bufc, sink}) <= 1), 1);
        end
    end

    task automatic powerup_tc();
        pdn_bit = 1'b0;
        tick(1'b0);
        for (int i = 1; i <= CLAMP; i++) begin
            chk("R5", "clamp before strobe", longint'(clamp), 1);
            strobe();
            chk("R5", "clamp", longint'(clamp), (i < CLAMP) ? 1 : 0);
        end
        chk("R6", "busy at ramp start", longint'(busy), 1);
        chk("R6", "buf during ramp", longint'(bufc), 1);
        chk("R6", "level at ramp start", longint'(level), 0);
        for (int k = 1; k <= RAMP; k++) begin
            tick(1'b0);
            chk("R6", "level between strobes", longint'(level), ramp_exp(k - 1));
            tick(1'b1);
            chk("R6", "level", longint'(level), ramp_exp(k));
            chk("R6", "busy", longint'(busy), (k < RAMP) ? 1 : 0);
            chk("R7", "audio", longint'(audio), (k == RAMP) ? 1 : 0);
        end
        chk("R7", "level full", longint'(level), FULL);
    endtask

    task automatic powerup_fast();
        pdn_bit = 1'b0;
        tick(1'b0);
        chk("R4", "buf on entry", longint'(bufc), 1);
        chk("R4", "clamp released", longint'(clamp), 0);
        for (int i = 1; i <= FAST; i++) begin
            tick((i % 3) == 0);
            chk("R4", "audio", longint'(audio), (i == FAST) ? 1 : 0);
            chk("R4", "buf", longint'(bufc), (i < FAST) ? 1 : 0);
        end
        chk("R7", "level full fast", longint'(level), FULL);
    endtask

    task automatic powerdown();
        pdn_bit = 1'b1;
        tick(1'b0);
        chk("R8", "audio off", longint'(audio), 0);
        chk("R8", "sink on", longint'(sink), 1);
        chk("R8", "level cleared", longint'(level), 0);
        for (int i = 1; i <= SINK; i++) begin
            strobe();
            chk("R8", "sink", longint'(sink), (i < SINK) ? 1 : 0);
            chk("R8", "done", longint'(done), (i == SINK) ? 1 : 0);
        end
        repeat (3) strobe();
        chk("R8", "stays off", longint'(audio | bufc | sink), 0);
        chk("R8", "done held", longint'(done), 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int dummy;
        dummy    = $urandom(32'h0005_EED5);
        rst_n    = 1'b0;
        mode_sel = 1'b1;
        pdn_bit  = 1'b1;
        tc_en    = 1'b1;
        lr_stb   = 1'b0;
        repeat (3) @(negedge clk);

        // R1 reset state
        chk("R1", "clamp", longint'(clamp), 1);
        chk("R1", "level", longint'(level), 0);
        chk("R1", "paths", longint'({audio, bufc, sink, busy}), 0);
        chk("R1", "ready/done", longint'({ready, done}), 0);

        // R2/R3 control-port capture and hold
        rst_n = 1'b1;
        tick(1'b0);
        mon_on = 1'b1;
        chk("R3", "ready", longint'(ready), 1);
        mode_sel = 1'b0;
        repeat (6) strobe();
        chk("R2", "ready after pin change", longint'(ready), 1);
        chk("R3", "clamp held", longint'(clamp), 1);
        chk("R3", "no buffer/audio", longint'(bufc | audio), 0);

        // R5..R8 full transient-controlled cycle
        powerup_tc();
        powerdown();

        // R4 fast path restart from powered-down
        tc_en = 1'b0;
        powerup_fast();
        powerdown();

        // R10 abort during ramp
        tc_en = 1'b1;
        pdn_bit = 1'b0;
        tick(1'b0);
        repeat (CLAMP) strobe();
        begin
            int r = $urandom_range(1, RAMP - 1);
            repeat (r) strobe();
            chk("R10", "ramp level before abort", longint'(level), ramp_exp(r));
        end
        pdn_bit = 1'b1;
        tick(1'b1);
        chk("R10", "sink after ramp abort", longint'(sink), 1);
        chk("R10", "busy cleared", longint'(busy), 0);
        chk("R10", "level cleared", longint'(level), 0);
        repeat (SINK) strobe();
        chk("R8", "done after abort", longint'(done), 1);

        // R10 abort during clamp
        pdn_bit = 1'b0;
        tick(1'b0);
        repeat ($urandom_range(1, CLAMP - 1)) strobe();
        chk("R10", "clamp before abort", longint'(clamp), 1);
        pdn_bit = 1'b1;
        tick(1'b0);
        chk("R10", "sink after clamp abort", longint'(sink), 1);
        chk("R10", "clamp released", longint'(clamp), 0);

        // R12 reset in the middle of discharge
        repeat (2) strobe();
        rst_n = 1'b0;
        #1;
        chk("R12", "sink off at once", longint'(sink), 0);
        chk("R12", "clamp at once", longint'(clamp), 1);
        tick(1'b0);
        chk("R12", "ready cleared", longint'(ready), 0);

        // R11 stand-alone start, power-down bit ignored
        mode_sel = 1'b0;
        pdn_bit  = 1'b1;
        tc_en    = 1'b1;
        rst_n    = 1'b1;
        tick(1'b0);
        tick(1'b0);
        chk("R11", "no port", longint'(ready), 0);
        for (int i = 1; i <= CLAMP; i++) strobe();
        chk("R11", "clamp released", longint'(clamp), 0);
        for (int i = 1; i <= RAMP; i++) strobe();
        chk("R11", "audio on", longint'(audio), 1);
        pdn_bit = 1'b0;
        tick(1'b0);
        pdn_bit = 1'b1;
        repeat (4) strobe();
        chk("R11", "audio kept", longint'(audio), 1);
        chk("R11", "no sink", longint'(sink), 0);

        // Random cycles in control-port mode
        rst_n = 1'b0;
        tick(1'b0);
        mode_sel = 1'b1;
        rst_n    = 1'b1;
        tick(1'b0);
        for (int it = 0; it < 4; it++) begin
            tc_en = 1'($urandom_range(0, 1));
            if (tc_en) powerup_tc();
            else       powerup_fast();
            powerdown();
        end

        mon_on = 1'b0;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule